// File: doc/BRIEF.md
# Integer Compare and Conditional-Move ALU

This block is the 64-bit integer execution unit of a scalar pipeline. Each cycle it may accept one operation: two register operands (or an 8-bit immediate standing in for the second operand), a 5-bit operation code, and the present value of the destination register. It covers full-width and 32-bit addition and subtraction, addition and subtraction with the first operand scaled by 4 or 8, the three bitwise operations and their forms with the second operand inverted, left, logical-right and arithmetic-right shifts, signed and unsigned compares, and conditional moves driven by eight tests on the first operand.

The unit has one register stage. It returns the 64-bit result and a write-enable one clock after the operation is accepted. A conditional move whose test fails drops the write-enable and passes the old destination value through unchanged, so the register file may either gate on the enable or write back blindly. Overflow traps, multiplication and the register file itself lie outside the block.

Top module: `xu_int_alu`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_we` and `out_result` are all 0. An operation with `in_valid` high at a rising edge appears on the outputs just after that edge, with `out_valid` high.
- R2: With `use_imm` = 1, operand 2 is `imm` zero-extended to 64 bits and `src_b` has no effect. With `use_imm` = 0, operand 2 is `src_b`.
- R3: Codes 0..5 give a+b, a-b, 4a+b, 8a+b, 4a-b and 8a-b, all modulo 2^64, where a is `src_a` and b is operand 2.
- R4: Codes 6 and 7 form the 32-bit sum a+b and difference a-b of the low halves and sign-extend bit 31 into bits 63..32.
- R5: Codes 8..13 give a&b, a&~b, a|b, a|~b, a^b and ~(a^b).
- R6: Codes 14, 15 and 16 shift a left, right with zero fill and right with sign fill. The shift distance is bits 5..0 of operand 2, and higher bits are ignored.
- R7: Codes 17..21 give 1 when a==b, a<b signed, a<=b signed, a<b unsigned and a<=b unsigned respectively, and 0 otherwise. Bits 63..1 are always 0.
- R8: Codes 22..29 are conditional moves that test a as a signed value: zero, non-zero, negative, negative-or-zero, positive, non-negative, bit 0 set, bit 0 clear. When the test holds, the result is operand 2 and `out_we` is 1.
- R9: When a conditional-move test fails, `out_we` is 0 and `out_result` equals the `dest_old` value supplied with the operation.
- R10: Every operation with code 0..21 sets `out_we`. Codes 30 and 31 are reserved: they give result 0 with `out_we` 0.
- R11: A cycle with `in_valid` low yields `out_valid` 0 and `out_we` 0, and `out_result` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-flop synchronizer |
| in_valid | input | 1 | An operation is presented this cycle |
| op | input | 5 | Operation code (see requirements) |
| use_imm | input | 1 | Use the immediate as operand 2 |
| imm | input | 8 | Immediate, zero-extended |
| src_a | input | 64 | Operand 1 |
| src_b | input | 64 | Operand 2 when `use_imm` is 0 |
| dest_old | input | 64 | Current destination value, returned by a failed conditional move |
| out_valid | output | 1 | Registered result is valid |
| out_we | output | 1 | Destination is to be written |
| out_result | output | 64 | Registered 64-bit result |

## Verification
Every operation code is driven with values on either side of the sign boundary, the 32-bit boundary, and both extremes. A swapped signed/unsigned compare, or a sign-extension taken from the wrong bit, would then produce a wrong 0/1 or a wrong upper half. Every immediate value is applied to every code. This shows up a missing zero-extension, a `src_b` that leaks through, and shift distances of 64 and above that were not masked to six bits. For every conditional-move test, operands are chosen so that the test both holds and fails. A design that wrote 0 instead of the old destination value, or that left the write-enable high, would be caught. Idle cycles come after real results, so that a result register clocked without its enable shows up as a changed output.

// File: rtl/xu_alu_pkg.sv
package xu_alu_pkg;

  localparam int OP_W = 5;
  typedef logic [OP_W-1:0] xu_op_t;

  // arithmetic group
  localparam xu_op_t OP_ADDQ    = 5'd0;
  localparam xu_op_t OP_SUBQ    = 5'd1;
  localparam xu_op_t OP_ADDQ_X4 = 5'd2;
  localparam xu_op_t OP_ADDQ_X8 = 5'd3;
  localparam xu_op_t OP_SUBQ_X4 = 5'd4;
  localparam xu_op_t OP_SUBQ_X8 = 5'd5;
  localparam xu_op_t OP_ADDL    = 5'd6;
  localparam xu_op_t OP_SUBL    = 5'd7;
  // bitwise group
  localparam xu_op_t OP_AND     = 5'd8;
  localparam xu_op_t OP_ANDN    = 5'd9;
  localparam xu_op_t OP_OR      = 5'd10;
  localparam xu_op_t OP_ORN     = 5'd11;
  localparam xu_op_t OP_XOR     = 5'd12;
  localparam xu_op_t OP_XNOR    = 5'd13;
  // shift group
  localparam xu_op_t OP_SHL     = 5'd14;
  localparam xu_op_t OP_SHR     = 5'd15;
  localparam xu_op_t OP_SHRA    = 5'd16;
  // compare group
  localparam xu_op_t OP_CEQ     = 5'd17;
  localparam xu_op_t OP_CLT     = 5'd18;
  localparam xu_op_t OP_CLE     = 5'd19;
  localparam xu_op_t OP_CLTU    = 5'd20;
  localparam xu_op_t OP_CLEU    = 5'd21;
  // conditional move group
  localparam xu_op_t OP_MVZ     = 5'd22;
  localparam xu_op_t OP_MVNZ    = 5'd23;
  localparam xu_op_t OP_MVNEG   = 5'd24;
  localparam xu_op_t OP_MVNPOS  = 5'd25;
  localparam xu_op_t OP_MVPOS   = 5'd26;
  localparam xu_op_t OP_MVNNEG  = 5'd27;
  localparam xu_op_t OP_MVODD   = 5'd28;
  localparam xu_op_t OP_MVEVEN  = 5'd29;

  typedef enum logic [2:0] {
    CLS_ARITH, CLS_LOGIC, CLS_SHIFT, CLS_CMP, CLS_CMOV, CLS_NONE
  } xu_cls_e;

  function automatic xu_cls_e op_class(input xu_op_t op);
    if (op <= OP_SUBL)        return CLS_ARITH;
    else if (op <= OP_XNOR)   return CLS_LOGIC;
    else if (op <= OP_SHRA)   return CLS_SHIFT;
    else if (op <= OP_CLEU)   return CLS_CMP;
    else if (op <= OP_MVEVEN) return CLS_CMOV;
    else                      return CLS_NONE;
  endfunction

endpackage

// File: rtl/xu_addsub.sv
module xu_addsub
  import xu_alu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  xu_op_t            op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] arith_res,
  output logic [DATA_W-1:0] cmp_res
);

  localparam int LW_W = DATA_W / 2;

  logic              do_sub;
  logic              is_long;
  logic [1:0]        scale;
  logic [DATA_W-1:0] a_scaled;
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W-1:0] sum;
  logic              eq, ult, slt, hit;

  // decode of the shared adder
  always_comb begin
    do_sub  = 1'b0;
    is_long = 1'b0;
    scale   = 2'd0;
    case (op)
      OP_SUBQ:    do_sub = 1'b1;
      OP_ADDQ_X4: scale  = 2'd2;
      OP_ADDQ_X8: scale  = 2'd3;
      OP_SUBQ_X4: begin scale = 2'd2; do_sub = 1'b1; end
      OP_SUBQ_X8: begin scale = 2'd3; do_sub = 1'b1; end
      OP_ADDL:    is_long = 1'b1;
      OP_SUBL:    begin is_long = 1'b1; do_sub = 1'b1; end
      default:    ;
    endcase
  end

  always_comb begin
    case (scale)
      2'd2:    a_scaled = {a[DATA_W-3:0], 2'b00};
      2'd3:    a_scaled = {a[DATA_W-4:0], 3'b000};
      default: a_scaled = a;
    endcase
    b_eff = do_sub ? ~b : b;
    sum   = a_scaled + b_eff + {{(DATA_W-1){1'b0}}, do_sub};
    if (is_long)
      arith_res = {{LW_W{sum[LW_W-1]}}, sum[LW_W-1:0]};
    else
      arith_res = sum;
  end

  // compares
  always_comb begin
    eq  = (a == b);
    ult = (a < b);
    slt = (a[DATA_W-1] != b[DATA_W-1]) ? a[DATA_W-1] : ult;
    case (op)
      OP_CEQ:  hit = eq;
      OP_CLT:  hit = slt;
      OP_CLE:  hit = slt | eq;
      OP_CLTU: hit = ult;
      OP_CLEU: hit = ult | eq;
      default: hit = 1'b0;
    endcase
    cmp_res = {{(DATA_W-1){1'b0}}, hit};
  end

  always_comb begin
    if (eq) begin
      assert_cmp_eq_not_less_R7: assert (!slt && !ult)
        else $error("equal operands reported as less");
    end
    if (op == OP_SUBQ && a == b) begin
      assert_sub_self_zero_R3: assert (arith_res == '0)
        else $error("a-a is not zero");
    end
  end

endmodule

// File: rtl/xu_logic_shift.sv
module xu_logic_shift
  import xu_alu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  xu_op_t            op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [SH_W-1:0]   shamt,
  output logic [DATA_W-1:0] logic_res,
  output logic [DATA_W-1:0] shift_res
);

  logic [DATA_W-1:0] b_eff;
  logic              inv_b;
  logic              go_left;
  logic              fill;
  logic [DATA_W-1:0] stg [0:SH_W];

  function automatic logic [DATA_W-1:0] bit_rev(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = v[DATA_W-1-i];
    return r;
  endfunction

  // bitwise operations with optional inverted operand 2
  always_comb begin
    inv_b = (op == OP_ANDN) || (op == OP_ORN) || (op == OP_XNOR);
    b_eff = inv_b ? ~b : b;
    case (op)
      OP_AND, OP_ANDN: logic_res = a & b_eff;
      OP_OR,  OP_ORN:  logic_res = a | b_eff;
      default:         logic_res = a ^ b_eff;
    endcase
  end

  // logarithmic right shifter; left shifts run through it bit-reversed
  always_comb begin
    go_left = (op == OP_SHL);
    fill    = (op == OP_SHRA) & a[DATA_W-1];
  end

  assign stg[0] = go_left ? bit_rev(a) : a;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stg[k+1] = shamt[k] ? {{STEP{fill}}, stg[k][DATA_W-1:STEP]} : stg[k];
  end

  assign shift_res = go_left ? bit_rev(stg[SH_W]) : stg[SH_W];

  always_comb begin
    if (op == OP_SHR) begin
      assert_shr_no_growth_R6: assert (shift_res <= a)
        else $error("logical right shift grew the value");
    end
  end

endmodule

// File: rtl/xu_cond_eval.sv
module xu_cond_eval
  import xu_alu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  xu_op_t            op,
  input  logic [DATA_W-1:0] a,
  output logic              take
);

  logic is_zero, is_neg, is_odd;

  always_comb begin
    is_zero = (a == '0);
    is_neg  = a[DATA_W-1];
    is_odd  = a[0];
    case (op)
      OP_MVZ:    take = is_zero;
      OP_MVNZ:   take = !is_zero;
      OP_MVNEG:  take = is_neg;
      OP_MVNPOS: take = is_neg | is_zero;
      OP_MVPOS:  take = !is_neg & !is_zero;
      OP_MVNNEG: take = !is_neg;
      OP_MVODD:  take = is_odd;
      OP_MVEVEN: take = !is_odd;
      default:   take = 1'b0;
    endcase
  end

endmodule

// File: rtl/xu_int_alu.sv
module xu_int_alu
  import xu_alu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [4:0]        op,
  input  logic              use_imm,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] dest_old,
  output logic              out_valid,
  output logic              out_we,
  output logic [DATA_W-1:0] out_result
);

  localparam int SH_W = $clog2(DATA_W);

  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] arith_res, cmp_res, logic_res, shift_res;
  logic              take;
  xu_cls_e           cls;
  logic [DATA_W-1:0] calc_res;
  logic              calc_we;
  logic              valid_d, valid_q, we_d, we_q;
  logic [DATA_W-1:0] res_d, res_q;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign opnd_b = use_imm ? {{(DATA_W-IMM_W){1'b0}}, imm} : src_b;

  xu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .op(op), .a(src_a), .b(opnd_b),
    .arith_res(arith_res), .cmp_res(cmp_res)
  );

  xu_logic_shift #(.DATA_W(DATA_W), .SH_W(SH_W)) u_lsh (
    .op(op), .a(src_a), .b(opnd_b), .shamt(opnd_b[SH_W-1:0]),
    .logic_res(logic_res), .shift_res(shift_res)
  );

  xu_cond_eval #(.DATA_W(DATA_W)) u_cond (
    .op(op), .a(src_a), .take(take)
  );

  // result select
  always_comb begin
    cls = op_class(op);
    calc_we = 1'b1;
    case (cls)
      CLS_ARITH: calc_res = arith_res;
      CLS_LOGIC: calc_res = logic_res;
      CLS_SHIFT: calc_res = shift_res;
      CLS_CMP:   calc_res = cmp_res;
      CLS_CMOV:  begin
        calc_res = take ? opnd_b : dest_old;
        calc_we  = take;
      end
      default:   begin
        calc_res = '0;
        calc_we  = 1'b0;
      end
    endcase
  end

  // next state
  always_comb begin
    valid_d = in_valid;
    we_d    = 1'b0;
    res_d   = res_q;
    if (in_valid) begin
      we_d  = calc_we;
      res_d = calc_res;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      valid_q <= 1'b0;
      we_q    <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= valid_d;
      we_q    <= we_d;
      res_q   <= res_d;
    end
  end

  assign out_valid  = valid_q;
  assign out_we     = we_q;
  assign out_result = res_q;

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid |=> out_valid);

  assert_idle_holds_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> (!out_valid && !out_we && $stable(out_result)));

  assert_we_needs_valid_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_we |-> out_valid);

  assert_cmov_keeps_dest_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && op_class(op) == CLS_CMOV && !take) |=>
      (!out_we && out_result == $past(dest_old)));

  assert_cmp_boolean_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && op_class(op) == CLS_CMP) |=> (out_result[DATA_W-1:1] == '0));

  assert_reserved_quiet_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && op_class(op) == CLS_NONE) |=> (!out_we && out_result == '0));

endmodule

// File: tb/sim_xu_int_alu.sv
module sim_xu_int_alu;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [4:0]  op;
  logic        use_imm;
  logic [7:0]  imm;
  logic [63:0] src_a, src_b, dest_old;
  logic        out_valid, out_we;
  logic [63:0] out_result;

  int checks = 0;
  int errs   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xu_int_alu u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .use_imm(use_imm), .imm(imm), .src_a(src_a), .src_b(src_b),
    .dest_old(dest_old), .out_valid(out_valid), .out_we(out_we),
    .out_result(out_result)
  );

  function automatic logic [63:0] pat(input int i);
    case (i % 10)
      0: return 64'h0;
      1: return 64'h1;
      2: return 64'hFFFF_FFFF_FFFF_FFFF;
      3: return 64'h8000_0000_0000_0000;
      4: return 64'h7FFF_FFFF_FFFF_FFFF;
      5: return 64'h0000_0000_7FFF_FFFF;
      6: return 64'h0000_0000_8000_0000;
      7: return 64'hDEAD_BEEF_0123_4567;
      8: return 64'h5555_5555_AAAA_AAAA;
      default: return 64'h0F0F_F0F0_1234_8002;
    endcase
  endfunction

  function automatic string req_of(input int code);
    if (code <= 5)       return "R3";
    else if (code <= 7)  return "R4";
    else if (code <= 13) return "R5";
    else if (code <= 16) return "R6";
    else if (code <= 21) return "R7";
    else if (code <= 29) return "R8/R9";
    else                 return "R10";
  endfunction

  // expected {we, result} from the requirement text
  function automatic logic [64:0] model(input int code, input logic [63:0] a,
                                        input logic [63:0] b, input logic [63:0] d);
    logic [63:0] r;
    logic [31:0] l;
    logic        w, c;
    logic signed [63:0] sa, sb;
    sa = a; sb = b; w = 1'b1; r = 64'h0; c = 1'b0;
    case (code)
      0: r = a + b;
      1: r = a - b;
      2: r = a * 4 + b;
      3: r = a * 8 + b;
      4: r = a * 4 - b;
      5: r = a * 8 - b;
      6: begin l = a[31:0] + b[31:0]; r = {{32{l[31]}}, l}; end
      7: begin l = a[31:0] - b[31:0]; r = {{32{l[31]}}, l}; end
      8: r = a & b;
      9: r = a & ~b;
      10: r = a | b;
      11: r = a | ~b;
      12: r = a ^ b;
      13: r = ~(a ^ b);
      14: r = a << b[5:0];
      15: r = a >> b[5:0];
      16: r = sa >>> b[5:0];
      17: r = {63'b0, a == b};
      18: r = {63'b0, sa < sb};
      19: r = {63'b0, sa <= sb};
      20: r = {63'b0, a < b};
      21: r = {63'b0, a <= b};
      22, 23, 24, 25, 26, 27, 28, 29: begin
        case (code)
          22: c = (sa == 0);
          23: c = (sa != 0);
          24: c = (sa < 0);
          25: c = (sa <= 0);
          26: c = (sa > 0);
          27: c = (sa >= 0);
          28: c = a[0];
          default: c = !a[0];
        endcase
        w = c;
        r = c ? b : d;
      end
      default: begin w = 1'b0; r = 64'h0; end
    endcase
    return {w, r};
  endfunction

  logic [63:0] last_res;

  task automatic run(input int code, input logic [63:0] a, input logic [63:0] b,
                     input logic [63:0] d, input logic ui, input logic [7:0] im);
    logic [63:0] b2;
    logic [64:0] e;
    @(negedge clk);
    in_valid = 1'b1; op = code[4:0]; src_a = a; src_b = b;
    dest_old = d; use_imm = ui; imm = im;
    @(negedge clk);
    b2 = ui ? {56'b0, im} : b;
    e  = model(code, a, b2, d);
    checks++;
    if (out_valid !== 1'b1 || out_we !== e[64] || out_result !== e[63:0]) begin
      errs++;
      $display("FAIL %s (imm R2=%0b) op=%0d a=%h b=%h: got v=%b we=%b res=%h exp we=%b res=%h",
               req_of(code), ui, code, a, b2, out_valid, out_we, out_result, e[64], e[63:0]);
    end
    last_res = e[63:0];
  endtask

  task automatic idle_check();
    @(negedge clk);
    in_valid = 1'b0; op = 5'd0; src_a = ~src_a; src_b = ~src_b; dest_old = ~dest_old;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_we !== 1'b0 || out_result !== last_res) begin
      errs++;
      $display("FAIL R11 idle: got v=%b we=%b res=%h exp v=0 we=0 res=%h",
               out_valid, out_we, out_result, last_res);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b1; op = 5'd0; use_imm = 1'b0; imm = 8'h0;
    src_a = 64'h1234; src_b = 64'h1; dest_old = 64'h0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_we !== 1'b0 || out_result !== 64'h0) begin
      errs++;
      $display("FAIL R1 during reset: got v=%b we=%b res=%h exp all 0",
               out_valid, out_we, out_result);
    end
    in_valid = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_we !== 1'b0 || out_result !== 64'h0) begin
      errs++;
      $display("FAIL R1 after release: got v=%b we=%b res=%h exp all 0",
               out_valid, out_we, out_result);
    end

    // register operand sweep over all codes (R3..R10)
    for (int code = 0; code < 32; code++)
      for (int i = 0; i < 10; i++)
        for (int j = 0; j < 10; j++)
          run(code, pat(i), pat(j), pat(i + j + 3) ^ 64'hC0DE, 1'b0, 8'h00);

    // immediate sweep, src_b poisoned (R2)
    for (int code = 0; code < 32; code++)
      for (int k = 0; k < 256; k++)
        run(code, pat(k), ~pat(k + 1), pat(k + 5), 1'b1, k[7:0]);

    // shift distances with junk in upper bits (R6)
    for (int code = 14; code <= 16; code++)
      for (int s = 0; s < 64; s++)
        run(code, pat(7 + (s % 3)), {pat(7)[63:6], s[5:0]}, 64'h0, 1'b0, 8'h00);

    // idle after a non-zero result (R11)
    run(0, 64'h10, 64'h20, 64'h0, 1'b0, 8'h0);
    idle_check();
    run(28, 64'h2, 64'h99, 64'hABCD, 1'b0, 8'h0);  // R9: test fails
    idle_check();

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule